// File: doc/BRIEF.md
# Supply-Fault Reset Stretcher

This block turns one or more digital supply-fault flags into a single active-low reset for downstream logic. Each flag comes from an analog comparator outside the block, and a 1 on a flag means that supply is below its threshold. A flag must stay set for a minimum number of consecutive clock cycles before the block believes it. This filtering drops short dips. Once a fault has been qualified, the reset output goes low on the next clock edge. It stays low while any qualified fault remains present. After every supply is good again, the output stays low for a further fixed hold time and then goes high.

A second source can also drive the output low. A single-cycle request strobe, for example from a long-press manual-reset detector, starts a reset pulse of fixed length. A new strobe during that pulse starts it again from the beginning. The final output is low whenever either source asks for reset, so a manual pulse never shortens a supply-driven reset. Both timeouts count ticks from a shared prescaler. A prescaler of one gives one tick per clock.

After power-on reset the output is low, and every supply is taken to be faulty until its flag has been sampled clear.

Top module: `supply_reset_stretch`

## Requirements
- R1: While `rst` is high and after it falls, `rst_n_out` is 0. With all fault flags 0 from the first cycle after reset, it stays 0 for HOLD_TICKS ticks and then rises.
- R2: A fault flag (1 = supply low) sampled high on FILT_CYC consecutive rising edges becomes a qualified fault. `rst_n_out` is 0 after the following edge.
- R3: A fault flag that is high on fewer than FILT_CYC consecutive edges does not change `rst_n_out`.
- R4: With TICK_DIV = 1, the first edge that samples all flags at 0 is edge m. `rst_n_out` returns to 1 exactly after edge m + HOLD_TICKS + 1, provided no manual pulse is active.
- R5: A qualified fault that returns during the hold time restarts the hold time from zero once all flags are clear again.
- R6: With two supplies, release requires both flags to be clear together. The hold time starts only when the last fault clears.
- R7: A `man_req` strobe sampled at edge j drives `rst_n_out` to 0 for exactly MAN_TICKS ticks, from after edge j+1 through edge j+MAN_TICKS. A new strobe during the pulse restarts it.
- R8: `rst_n_out` is the active-low OR of the supply reset and the manual pulse. Neither source shortens the other.
- R9: While any qualified fault is present, `rst_n_out` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_low | input | N_SUP | Per-supply fault flag from the comparators, 1 = below threshold |
| man_req | input | 1 | Single-cycle manual reset pulse request |
| rst_n_out | output | 1 | Registered reset output, active low |

## Verification
The assertions assume that `sup_low` and `man_req` are already synchronous to `clk`. They also assume `rst` is held for at least two cycles, so that no past value is sampled from before reset. The bench drives all inputs on the falling clock edge and holds reset for several cycles. Its random phase flips each fault flag rarely, with runs of mixed length that fall on both sides of the filter length. It sends manual strobes at random moments, including during supply resets. Directed phases cover glitches exactly one cycle short of qualifying, faults that return during the hold time, and staggered faults on two supplies.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  // counter width able to hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rsx_tick_gen.sv
module rsx_tick_gen #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  import rsx_pkg::*;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned TW = cnt_w(TICK_DIV);
      localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);
      logic [TW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);

      tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    end
  endgenerate
endmodule

// File: rtl/rsx_fault_filter.sv
module rsx_fault_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic flt
);
  import rsx_pkg::*;

  localparam int unsigned CW = cnt_w(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run;

  // run counts earlier consecutive high samples; saturates at LAST
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= LAST;
      flt <= 1'b1;
    end else if (!raw) begin
      run <= '0;
      flt <= 1'b0;
    end else if (run == LAST) begin
      flt <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R3
  qualify_chk: assert property (@(posedge clk) disable iff (rst)
    (flt && !$past(flt)) |-> $past(raw));
endmodule

// File: rtl/rsx_hold_timer.sv
module rsx_hold_timer #(
  parameter int unsigned HOLD_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fault,
  output logic hold
);
  import rsx_pkg::*;

  localparam int unsigned HW = cnt_w(HOLD_TICKS);
  localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (fault) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (hold && tick) begin
      if (cnt == LAST) hold <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault && $past(fault)) |-> (hold && cnt == '0));
endmodule

// File: rtl/rsx_man_pulse.sv
module rsx_man_pulse #(
  parameter int unsigned MAN_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req,
  output logic act
);
  import rsx_pkg::*;

  localparam int unsigned MW = cnt_w(MAN_TICKS);
  localparam logic [MW-1:0] LAST = MW'(MAN_TICKS - 1);

  logic [MW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (req) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (act && tick) begin
      if (cnt == LAST) act <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  // R7
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !$past(act)) |-> $past(req));
endmodule

// File: rtl/supply_reset_stretch.sv
module supply_reset_stretch #(
  parameter int unsigned N_SUP      = 2,
  parameter int unsigned FILT_CYC   = 4,
  parameter int unsigned HOLD_TICKS = 20,
  parameter int unsigned MAN_TICKS  = 12,
  parameter int unsigned TICK_DIV   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SUP-1:0] sup_low,
  input  logic             man_req,
  output logic             rst_n_out
);
  logic             tick;
  logic [N_SUP-1:0] flt;
  logic             any_flt;
  logic             hold;
  logic             man_act;
  logic             rst_n_q;

  rsx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  generate
    for (genvar i = 0; i < N_SUP; i++) begin : g_sup
      rsx_fault_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst), .raw(sup_low[i]), .flt(flt[i])
      );
    end
  endgenerate

  assign any_flt = |flt;

  rsx_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick), .fault(any_flt), .hold(hold)
  );

  rsx_man_pulse #(.MAN_TICKS(MAN_TICKS)) u_man (
    .clk(clk), .rst(rst), .tick(tick), .req(man_req), .act(man_act)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_n_q <= 1'b0;
    else     rst_n_q <= ~(any_flt | hold | man_act);
  end

  assign rst_n_out = rst_n_q;

  // R9
  fault_low_chk: assert property (@(posedge clk) disable iff (rst)
    any_flt |=> !rst_n_out);

  // R8
  man_low_chk: assert property (@(posedge clk) disable iff (rst)
    man_act |=> !rst_n_out);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_n_out && !$past(rst_n_out)) |-> ($past(!hold) && $past(!any_flt)));
endmodule

// File: tb/supply_reset_stretch_tb.sv
module supply_reset_stretch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 2;
  localparam int FILT = 4;
  localparam int HOLD = 20;
  localparam int MANT = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] sup_low = '0;
  logic          man_req = 1'b0;
  logic          rst_n_out;

  supply_reset_stretch #(
    .N_SUP(NS), .FILT_CYC(FILT), .HOLD_TICKS(HOLD), .MAN_TICKS(MANT), .TICK_DIV(1)
  ) u_dut (
    .clk(clk), .rst(rst), .sup_low(sup_low), .man_req(man_req), .rst_n_out(rst_n_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_req = "R1";

  // expected-value model, built from the requirement text
  int run_len [NS];
  bit qual    [NS];
  int good_run;
  int man_left;
  bit exp_out;

  function automatic bit exp_level(bit anyq, bit holding, bit manual);
    return !(anyq || holding || manual);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin run_len[i] = FILT; qual[i] = 1; end
      good_run = 0; man_left = 0; exp_out = 0;
    end else begin
      bit anyq;
      anyq = 0;
      for (int i = 0; i < NS; i++) anyq |= qual[i];
      exp_out = exp_level(anyq, good_run < HOLD, man_left > 0);
      for (int i = 0; i < NS; i++) begin
        if (sup_low[i]) run_len[i] = (run_len[i] < FILT) ? run_len[i] + 1 : FILT;
        else run_len[i] = 0;
        qual[i] = (run_len[i] >= FILT);
      end
      good_run = anyq ? 0 : ((good_run < HOLD) ? good_run + 1 : HOLD);
      if (man_req) man_left = MANT;
      else if (man_left > 0) man_left--;
    end
    chk_on = 1;
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) check(rst_n_out === exp_out, cur_req, rst_n_out, exp_out);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    step(150000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h51A7));
    // R1: reset state and power-on hold
    cur_req = "R1";
    step(5);
    rst = 1'b0;
    step(HOLD + 5);

    // R2: a qualified fault pulls the output low
    cur_req = "R2";
    sup_low[0] = 1'b1;
    step(FILT + 6);
    check(rst_n_out == 1'b0, "R2", rst_n_out, 0);

    // R4: exact release latency
    cur_req = "R4";
    sup_low[0] = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rst_n_out == 1'b0 && n < 200);
    check(n == HOLD + 2, "R4", n, HOLD + 2);
    step(5);

    // R3: fault one cycle too short is ignored
    cur_req = "R3";
    sup_low[1] = 1'b1;
    step(FILT - 1);
    sup_low[1] = 1'b0;
    step(8);
    check(rst_n_out == 1'b1, "R3", rst_n_out, 1);

    // R5: fault returns mid-hold
    cur_req = "R5";
    sup_low[0] = 1'b1; step(FILT + 2);
    sup_low[0] = 1'b0; step(HOLD / 2);
    sup_low[0] = 1'b1; step(FILT + 1);
    sup_low[0] = 1'b0; step(HOLD + 5);

    // R6: staggered faults on two supplies
    cur_req = "R6";
    sup_low[0] = 1'b1; step(FILT + 3);
    sup_low[1] = 1'b1; step(3);
    sup_low[0] = 1'b0; step(HOLD - 4);
    check(rst_n_out == 1'b0, "R6", rst_n_out, 0);
    sup_low[1] = 1'b0; step(HOLD + 5);

    // R7: manual pulse length and retrigger
    cur_req = "R7";
    man_req = 1'b1; step(1); man_req = 1'b0;
    step(MANT + 4);
    man_req = 1'b1; step(1); man_req = 1'b0;
    step(5);
    man_req = 1'b1; step(1); man_req = 1'b0;
    step(MANT + 4);

    // R8: manual pulse inside a supply reset does not shorten it
    cur_req = "R8";
    sup_low = '1; step(FILT + 2);
    man_req = 1'b1; step(1); man_req = 1'b0;
    step(3);
    sup_low = '0;
    man_req = 1'b1; step(1); man_req = 1'b0;
    step(HOLD + MANT + 4);

    // R9: random mixed stimulus
    cur_req = "R9";
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < NS; i++)
        if ($urandom % 12 == 0) sup_low[i] = ~sup_low[i];
      man_req = ($urandom % 150 == 0);
      step(1);
    end
    man_req = 1'b0;
    sup_low = '0;
    step(HOLD + MANT + 5);
    check(rst_n_out == 1'b1, "R9", rst_n_out, 1);
    finish_run();
  end
endmodule